// File: doc/BRIEF.md
# Burst bus master with hold

This block drives a 32-bit external bus whose address and data pins are separate. An internal requester hands it a request: a start byte address, a byte mask, a burst length of one to four words, a direction, a privilege level and, for writes, the whole burst of write data. The block holds one such request in a single-entry slot, so the requester can move on while the bus works. Each request becomes one bus access. The access opens with a single address-strobe cycle, followed by one data transfer per word. Each transfer waits on an active-low ready input. Read words come back one at a time, and a done pulse marks the last one.

The external address carries only word bits (31 down to 2), and byte enables select the bytes within the word. Within a burst only the two lowest word-address bits count up, so a burst never leaves its 16-byte aligned block. The block rejects a request that would leave that block with an error pulse. It also rejects an empty request the same way.

Another agent may ask for the bus with a hold request. The block finishes any access in progress, then raises hold acknowledge and drops the output enables of its address, control and data outputs. A request that arrives during this time waits in the slot until the bus is returned.

Top module: `xbus_master`

## Requirements
- R1: After reset: `req_ready`=1, `bus_ctl_oe`=1, `bus_strobe`=0, `bus_data_oe`=0, `hold_ack`=0, and `rsp_rvalid`, `rsp_done`, `rsp_err` are all 0.
- R2: A request taken at clock edge E starts its access at edge E+1. For exactly one cycle after E+1, `bus_strobe` is 1, `bus_addr` is the request address bits 31:2, `bus_be` is the request mask (bit i enables byte lane i) and `bus_write` is the direction (1 = write).
- R3: `bus_rdy_n` is ignored in the strobe cycle. After that, each transfer ends on the first rising edge where `bus_rdy_n` is sampled 0. Each cycle with `bus_rdy_n`=1 is a wait state, and the address and write data stay unchanged through it.
- R4: Transfer k of a burst (k = 0 upward) presents word address {addr[31:4], (addr[3:2]+k) mod 4}. The bits above bit 3 never change within a burst.
- R5: In the cycle after a read transfer ends, `rsp_rvalid`=1 and `rsp_rdata` holds the `bus_din` sampled at that edge. `rsp_done` is 1 in that cycle for the final transfer only, and for a write `rsp_rvalid` stays 0.
- R6: During the transfers of a write, `bus_data_oe`=1 and `bus_dout` carries write word k, taken from `req_wdata[32k+31:32k]`. During a read, `bus_data_oe`=0.
- R7: `bus_user` equals the request's privilege bit (0 = supervisor, 1 = user) and stays constant from the strobe cycle to the end of the access.
- R8: A request with length 0, length above 4, or with addr[3:2]+length above 4 is rejected. `rsp_err` pulses for one cycle at the edge where the request would have started, no strobe follows, and `req_ready` is 1 again.
- R9: A hold request raised during an access does not interrupt it. `hold_ack` rises one cycle after the block is idle with `hold_req`=1, and while `hold_ack`=1 both `bus_ctl_oe` and `bus_data_oe` are 0.
- R10: One cycle after `hold_req` falls, `hold_ack` is 0 and `bus_ctl_oe` is 1 again.
- R11: The slot holds one request: `req_ready` is 0 while it is full, including during hold. A request taken during hold starts one cycle after the bus is returned, and a second request offered meanwhile is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Slot empty, request can be taken |
| req_addr | input | 32 | Start byte address |
| req_mask | input | 4 | Byte enables for every transfer |
| req_len | input | 3 | Burst length in words |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | 1 = user level, 0 = supervisor |
| req_wdata | input | 128 | Write words, word k at bits 32k+31:32k |
| rsp_rvalid | output | 1 | Read word valid |
| rsp_rdata | output | 32 | Read word |
| rsp_done | output | 1 | Final transfer of an access completed |
| rsp_err | output | 1 | Request rejected |
| bus_addr | output | 30 | Word address (bits 31:2) |
| bus_be | output | 4 | Byte enables, active high |
| bus_strobe | output | 1 | Address valid, new access begins |
| bus_write | output | 1 | Access direction |
| bus_user | output | 1 | Privilege: 0 supervisor, 1 user |
| bus_dout | output | 32 | Write data |
| bus_din | input | 32 | Read data |
| bus_rdy_n | input | 1 | Active-low transfer ready |
| bus_ctl_oe | output | 1 | Enable for address and control outputs |
| bus_data_oe | output | 1 | Enable for write data outputs |
| hold_req | input | 1 | External agent wants the bus |
| hold_ack | output | 1 | Bus handed over |

## Verification
The bench builds the block with its default parameters: 32-bit address and data and a four-word maximum burst. With these values every start position inside a 16-byte block can be reached, along with the longest legal burst and bursts that end exactly on a block edge. Lengths one past the limit and the highest address block are also reachable. A length field three bits wide makes length 0 and length 5 expressible, so both rejection paths are tested alongside the block-crossing case.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    XB_IDLE,
    XB_ADDR,
    XB_DATA,
    XB_HOLD
  } xb_state_e;
endpackage

// File: rtl/xbus_req_slot.sv
// Single-entry request holding register between requester and sequencer.
module xbus_req_slot #(
  parameter int AW   = 32,
  parameter int BEW  = 4,
  parameter int LENW = 3,
  parameter int WDW  = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [AW-1:0]   in_addr,
  input  logic [BEW-1:0]  in_mask,
  input  logic [LENW-1:0] in_len,
  input  logic            in_write,
  input  logic            in_user,
  input  logic [WDW-1:0]  in_wdata,
  input  logic            take,
  output logic            out_valid,
  output logic [AW-1:0]   out_addr,
  output logic [BEW-1:0]  out_mask,
  output logic [LENW-1:0] out_len,
  output logic            out_write,
  output logic            out_user,
  output logic [WDW-1:0]  out_wdata
);
  logic accept;

  assign in_ready = !out_valid;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)      out_valid <= 1'b0;
    else if (accept) out_valid <= 1'b1;
    else if (take)   out_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_addr  <= in_addr;
      out_mask  <= in_mask;
      out_len   <= in_len;
      out_write <= in_write;
      out_user  <= in_user;
      out_wdata <= in_wdata;
    end
  end
endmodule

// File: rtl/xbus_beat_gen.sv
// Transfer counter and in-block word address stepping for one burst.
module xbus_beat_gen #(
  parameter int WAW  = 30,
  parameter int BLKW = 2,
  parameter int LENW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            adv,
  input  logic [WAW-1:0]  start_word,
  input  logic [LENW-1:0] len,
  output logic [WAW-1:0]  word_addr,
  output logic [BLKW-1:0] beat_idx,
  output logic            last
);
  localparam logic [BLKW-1:0] STEP = 1;

  logic [LENW-1:0] len_q;

  // Only the in-block bits advance; the block number is never touched.
  function automatic logic [WAW-1:0] step_word(input logic [WAW-1:0] w);
    return {w[WAW-1:BLKW], w[BLKW-1:0] + STEP};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_addr <= '0;
      beat_idx  <= '0;
      len_q     <= '0;
    end else if (load) begin
      word_addr <= start_word;
      beat_idx  <= '0;
      len_q     <= len;
    end else if (adv) begin
      word_addr <= step_word(word_addr);
      beat_idx  <= beat_idx + STEP;
    end
  end

  assign last = (LENW'(beat_idx) + LENW'(1)) == len_q;
endmodule

// File: rtl/xbus_master.sv
module xbus_master
  import xbus_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int MAX_BEATS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [AW-1:0]           req_addr,
  input  logic [DW/8-1:0]         req_mask,
  input  logic [$clog2(MAX_BEATS):0] req_len,
  input  logic                    req_write,
  input  logic                    req_user,
  input  logic [MAX_BEATS*DW-1:0] req_wdata,
  output logic                    rsp_rvalid,
  output logic [DW-1:0]           rsp_rdata,
  output logic                    rsp_done,
  output logic                    rsp_err,
  output logic [AW-1:$clog2(DW/8)] bus_addr,
  output logic [DW/8-1:0]         bus_be,
  output logic                    bus_strobe,
  output logic                    bus_write,
  output logic                    bus_user,
  output logic [DW-1:0]           bus_dout,
  input  logic [DW-1:0]           bus_din,
  input  logic                    bus_rdy_n,
  output logic                    bus_ctl_oe,
  output logic                    bus_data_oe,
  input  logic                    hold_req,
  output logic                    hold_ack
);
  localparam int BEW  = DW / 8;
  localparam int WL   = $clog2(BEW);
  localparam int BLKW = $clog2(MAX_BEATS);
  localparam int LENW = BLKW + 1;
  localparam int WAW  = AW - WL;
  localparam int WDW  = MAX_BEATS * DW;

  // A burst is legal when it is non-empty and ends inside its aligned block.
  function automatic logic burst_fits(input logic [BLKW-1:0] blk,
                                      input logic [LENW-1:0] len);
    return (len != '0) && ((int'(blk) + int'(len)) <= MAX_BEATS);
  endfunction

  function automatic logic [DW-1:0] pick_word(input logic [WDW-1:0] all,
                                              input logic [BLKW-1:0] idx);
    return all[int'(idx)*DW +: DW];
  endfunction

  xb_state_e state_q, state_d;

  logic            s_valid, s_write, s_user;
  logic [AW-1:0]   s_addr;
  logic [BEW-1:0]  s_mask;
  logic [LENW-1:0] s_len;
  logic [WDW-1:0]  s_wdata;

  logic            a_write, a_user;
  logic [BEW-1:0]  a_mask;
  logic [WDW-1:0]  a_wdata;

  logic [WAW-1:0]  word_addr;
  logic [BLKW-1:0] beat_idx;

  // Named internal events, also observed by the bound checker.
  logic fire, start_ok, start_bad, grant, in_data, beat_done, beat_last;

  assign fire      = (state_q == XB_IDLE) && s_valid && !hold_req;
  assign start_ok  = fire && burst_fits(s_addr[WL+BLKW-1:WL], s_len);
  assign start_bad = fire && !burst_fits(s_addr[WL+BLKW-1:WL], s_len);
  assign grant     = (state_q == XB_IDLE) && hold_req;
  assign in_data   = (state_q == XB_DATA);
  assign beat_done = in_data && !bus_rdy_n;

  xbus_req_slot #(.AW(AW), .BEW(BEW), .LENW(LENW), .WDW(WDW)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_addr   (req_addr),
    .in_mask   (req_mask),
    .in_len    (req_len),
    .in_write  (req_write),
    .in_user   (req_user),
    .in_wdata  (req_wdata),
    .take      (fire),
    .out_valid (s_valid),
    .out_addr  (s_addr),
    .out_mask  (s_mask),
    .out_len   (s_len),
    .out_write (s_write),
    .out_user  (s_user),
    .out_wdata (s_wdata)
  );

  xbus_beat_gen #(.WAW(WAW), .BLKW(BLKW), .LENW(LENW)) u_beat (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_ok),
    .adv        (beat_done && !beat_last),
    .start_word (s_addr[AW-1:WL]),
    .len        (s_len),
    .word_addr  (word_addr),
    .beat_idx   (beat_idx),
    .last       (beat_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XB_IDLE: if (grant) state_d = XB_HOLD;
               else if (start_ok) state_d = XB_ADDR;
      XB_ADDR: state_d = XB_DATA;
      XB_DATA: if (beat_done && beat_last) state_d = XB_IDLE;
      XB_HOLD: if (!hold_req) state_d = XB_IDLE;
      default: state_d = XB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= XB_IDLE;
    else        state_q <= state_d;
  end

  // Attributes of the access in flight, fixed from strobe to last transfer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_write <= 1'b0;
      a_user  <= 1'b0;
      a_mask  <= '0;
      a_wdata <= '0;
    end else if (start_ok) begin
      a_write <= s_write;
      a_user  <= s_user;
      a_mask  <= s_mask;
      a_wdata <= s_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_rvalid <= 1'b0;
      rsp_done   <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_rvalid <= beat_done && !a_write;
      rsp_done   <= beat_done && beat_last;
      rsp_err    <= start_bad;
      if (beat_done) rsp_rdata <= bus_din;
    end
  end

  assign bus_addr    = word_addr;
  assign bus_be      = a_mask;
  assign bus_write   = a_write;
  assign bus_user    = a_user;
  assign bus_dout    = pick_word(a_wdata, beat_idx);
  assign bus_strobe  = (state_q == XB_ADDR);
  assign bus_ctl_oe  = (state_q != XB_HOLD);
  assign bus_data_oe = in_data && a_write;
  assign hold_ack    = (state_q == XB_HOLD);
endmodule

// File: rtl/xbus_master_chk.sv
module xbus_master_chk #(
  parameter int AW   = 32,
  parameter int WL   = 2,
  parameter int BLKW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold_req,
  input logic          hold_ack,
  input logic          bus_ctl_oe,
  input logic          bus_data_oe,
  input logic          bus_strobe,
  input logic          bus_user,
  input logic [AW-1:WL] bus_addr,
  input logic          rsp_err,
  input logic          rsp_done,
  input logic          in_data,
  input logic          beat_done,
  input logic          beat_last
);
  localparam int LO_HI = WL + BLKW - 1;
  localparam logic [BLKW-1:0] STEP = 1;

  a_r9_float_when_acked: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!bus_ctl_oe && !bus_data_oe));

  a_r9_no_grant_mid_access: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && hold_req) |=> !hold_ack);

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !hold_req) |=> (!hold_ack && bus_ctl_oe));

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |=> !bus_strobe);

  a_r3_wait_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !beat_done) |=> $stable(bus_addr));

  a_r4_block_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !beat_last) |=>
      ($stable(bus_addr[AW-1:LO_HI+1]) &&
       (bus_addr[LO_HI:WL] == $past(bus_addr[LO_HI:WL]) + STEP)));

  a_r7_user_steady: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> $stable(bus_user));

  a_r8_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !bus_strobe);

  a_r5_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(beat_done && beat_last));
endmodule

bind xbus_master xbus_master_chk #(.AW(AW), .WL(WL), .BLKW(BLKW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold_req    (hold_req),
  .hold_ack    (hold_ack),
  .bus_ctl_oe  (bus_ctl_oe),
  .bus_data_oe (bus_data_oe),
  .bus_strobe  (bus_strobe),
  .bus_user    (bus_user),
  .bus_addr    (bus_addr),
  .rsp_err     (rsp_err),
  .rsp_done    (rsp_done),
  .in_data     (in_data),
  .beat_done   (beat_done),
  .beat_last   (beat_last)
);

// File: tb/xbus_master_test.sv
`timescale 1ns/1ps
module xbus_master_test;
  localparam real CLK_HALF = 2.5;
  localparam int  WD_CYCLES = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic [3:0]   req_mask = '0;
  logic [2:0]   req_len = '0;
  logic         req_write = 1'b0;
  logic         req_user = 1'b0;
  logic [127:0] req_wdata = '0;
  logic         rsp_rvalid, rsp_done, rsp_err;
  logic [31:0]  rsp_rdata;
  logic [31:2]  bus_addr;
  logic [3:0]   bus_be;
  logic         bus_strobe, bus_write, bus_user, bus_ctl_oe, bus_data_oe, hold_ack;
  logic [31:0]  bus_dout;
  logic [31:0]  bus_din = '0;
  logic         bus_rdy_n = 1'b1;
  logic         hold_req = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_HALF) clk = ~clk;

  xbus_master uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_mask(req_mask), .req_len(req_len), .req_write(req_write),
    .req_user(req_user), .req_wdata(req_wdata),
    .rsp_rvalid(rsp_rvalid), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .rsp_err(rsp_err),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_strobe(bus_strobe),
    .bus_write(bus_write), .bus_user(bus_user), .bus_dout(bus_dout),
    .bus_din(bus_din), .bus_rdy_n(bus_rdy_n),
    .bus_ctl_oe(bus_ctl_oe), .bus_data_oe(bus_data_oe),
    .hold_req(hold_req), .hold_ack(hold_ack)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  mask;
    logic [2:0]  len;
    logic        wr;
    logic        usr;
    logic [3:0]  waits;
    logic        err;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 4'hF, 3'd1, 1'b0, 1'b0, 4'd0, 1'b0},
    '{32'h0000_2004, 4'h3, 3'd3, 1'b1, 1'b1, 4'd2, 1'b0},
    '{32'h8000_0010, 4'hF, 3'd4, 1'b0, 1'b1, 4'd1, 1'b0},
    '{32'h0000_300C, 4'hF, 3'd2, 1'b0, 1'b0, 4'd0, 1'b1},
    '{32'h0000_4000, 4'hF, 3'd5, 1'b0, 1'b0, 4'd0, 1'b1},
    '{32'h0000_5008, 4'hC, 3'd2, 1'b1, 1'b0, 4'd0, 1'b0},
    '{32'h0000_6000, 4'hF, 3'd0, 1'b1, 1'b1, 4'd0, 1'b1},
    '{32'hFFFF_FFF0, 4'h5, 3'd4, 1'b1, 1'b0, 4'd3, 1'b0}
  };

  function automatic logic [31:0] wword(input int vi, input int k);
    return 32'h5A00_0000 | (32'(vi) << 8) | 32'(k);
  endfunction

  function automatic logic [31:0] rword(input int vi, input int k);
    return 32'hD000_0000 + 32'(vi) * 32'h100 + 32'(k);
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Serve the data transfers of an access; called at the first data-phase negedge.
  task automatic serve(input int vi, input logic [31:0] addr, input int len,
                       input logic wr, input int waits);
    for (int k = 0; k < len; k++) begin
      logic [29:0] ew;
      ew = {addr[31:4], 2'(addr[3:2] + 2'(k))};
      chk("R4", "beat word address", {2'b00, bus_addr}, {2'b00, ew});
      chk("R6", "data enable", {31'd0, bus_data_oe}, {31'd0, wr});
      if (wr) chk("R6", "write word", bus_dout, wword(vi, k));
      for (int w = 0; w < waits; w++) begin
        @(negedge clk);
        chk("R3", "address during wait", {2'b00, bus_addr}, {2'b00, ew});
        chk("R3", "no completion in wait", {30'd0, rsp_rvalid, rsp_done}, 32'd0);
        if (wr) chk("R3", "write data during wait", bus_dout, wword(vi, k));
      end
      bus_rdy_n = 1'b0;
      bus_din   = rword(vi, k);
      @(negedge clk);
      bus_rdy_n = 1'b1;
      bus_din   = '0;
      chk("R5", "read valid", {31'd0, rsp_rvalid}, {31'd0, !wr});
      if (!wr) chk("R5", "read word", rsp_rdata, rword(vi, k));
      chk("R5", "done flag", {31'd0, rsp_done}, {31'd0, (k == len - 1)});
    end
  endtask

  task automatic do_access(input int vi, input vec_t v);
    req_addr  = v.addr;
    req_mask  = v.mask;
    req_len   = v.len;
    req_write = v.wr;
    req_user  = v.usr;
    for (int k = 0; k < 4; k++) req_wdata[k*32 +: 32] = wword(vi, k);
    req_valid = 1'b1;
    @(negedge clk);
    chk("R11", "slot full", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b0;
    @(negedge clk);
    if (v.err) begin
      chk("R8", "error pulse", {31'd0, rsp_err}, 32'd1);
      chk("R8", "no strobe", {31'd0, bus_strobe}, 32'd0);
      @(negedge clk);
      chk("R8", "error single", {31'd0, rsp_err}, 32'd0);
      chk("R8", "still no strobe", {31'd0, bus_strobe}, 32'd0);
      chk("R8", "slot free", {31'd0, req_ready}, 32'd1);
      return;
    end
    chk("R2", "strobe", {31'd0, bus_strobe}, 32'd1);
    chk("R2", "start address", {2'b00, bus_addr}, {2'b00, v.addr[31:2]});
    chk("R2", "byte enables", {28'd0, bus_be}, {28'd0, v.mask});
    chk("R2", "direction", {31'd0, bus_write}, {31'd0, v.wr});
    chk("R7", "privilege", {31'd0, bus_user}, {31'd0, v.usr});
    @(negedge clk);
    chk("R2", "strobe one cycle", {31'd0, bus_strobe}, 32'd0);
    serve(vi, v.addr, int'(v.len), v.wr, int'(v.waits));
    chk("R7", "privilege at end", {31'd0, bus_user}, {31'd0, v.usr});
    @(negedge clk);
    chk("R5", "done is a pulse", {31'd0, rsp_done}, 32'd0);
  endtask

  initial begin
    #(WD_CYCLES * 2 * CLK_HALF);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1", "strobe", {31'd0, bus_strobe}, 32'd0);
    chk("R1", "hold_ack", {31'd0, hold_ack}, 32'd0);
    chk("R1", "ctl enable", {31'd0, bus_ctl_oe}, 32'd1);
    chk("R1", "data enable", {31'd0, bus_data_oe}, 32'd0);
    chk("R1", "responses", {29'd0, rsp_rvalid, rsp_done, rsp_err}, 32'd0);

    for (int i = 0; i < NV; i++) do_access(i, VECS[i]);

    // R9/R10/R11: hold while idle, request queued during hold
    hold_req = 1'b1;
    @(negedge clk);
    chk("R9", "ack from idle", {31'd0, hold_ack}, 32'd1);
    chk("R9", "ctl floated", {31'd0, bus_ctl_oe}, 32'd0);
    chk("R9", "data floated", {31'd0, bus_data_oe}, 32'd0);
    req_addr = 32'h0000_6A00; req_mask = 4'hF; req_len = 3'd1;
    req_write = 1'b0; req_user = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    chk("R11", "taken during hold", {31'd0, req_ready}, 32'd0);
    req_addr = 32'h0000_9000; req_user = 1'b0;
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      chk("R11", "second not taken", {31'd0, req_ready}, 32'd0);
      chk("R11", "no start while held", {31'd0, bus_strobe}, 32'd0);
      chk("R9", "ack stays", {31'd0, hold_ack}, 32'd1);
    end
    req_valid = 1'b0;
    hold_req  = 1'b0;
    @(negedge clk);
    chk("R10", "ack dropped", {31'd0, hold_ack}, 32'd0);
    chk("R10", "ctl driven", {31'd0, bus_ctl_oe}, 32'd1);
    @(negedge clk);
    chk("R11", "queued start", {31'd0, bus_strobe}, 32'd1);
    chk("R11", "queued address", {2'b00, bus_addr}, {2'b00, 30'h0000_1A80});
    chk("R7", "queued privilege", {31'd0, bus_user}, 32'd1);
    @(negedge clk);
    serve(9, 32'h0000_6A00, 1, 1'b0, 0);
    @(negedge clk);
    chk("R11", "slot empty after", {31'd0, req_ready}, 32'd1);

    // R9: hold raised during a two-word read
    req_addr = 32'h0000_7008; req_mask = 4'hF; req_len = 3'd2;
    req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R2", "strobe before hold", {31'd0, bus_strobe}, 32'd1);
    hold_req = 1'b1;
    @(negedge clk);
    chk("R9", "no ack mid access", {31'd0, hold_ack}, 32'd0);
    chk("R9", "ctl still driven", {31'd0, bus_ctl_oe}, 32'd1);
    serve(10, 32'h0000_7008, 2, 1'b0, 1);
    chk("R9", "no ack at completion", {31'd0, hold_ack}, 32'd0);
    @(negedge clk);
    chk("R9", "ack after access", {31'd0, hold_ack}, 32'd1);
    chk("R9", "ctl floated after", {31'd0, bus_ctl_oe}, 32'd0);
    hold_req = 1'b0;
    @(negedge clk);
    chk("R10", "ack released", {31'd0, hold_ack}, 32'd0);
    chk("R10", "ctl back", {31'd0, bus_ctl_oe}, 32'd1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule